// File: doc/BRIEF.md
# Shift and Rotate Carry/Overflow Flag Generator

This block produces the carry (CF), overflow (OF) and extra-carry (ECF) flag bits for shift and rotate micro-operations on operands of 1, 2, 4 or 8 bytes. It receives the source operand, the already computed result from the datapath shifter, the raw shift count, the current flag values and a per-flag select mask. It returns the updated three-bit flag word. Zero, sign and parity flags belong to a separate result-flag path and are not produced here.

Each operation has its own carry and overflow rule. Large counts are clamped for the arithmetic right shift. The rotate-through-carry forms reduce the count modulo the operand width plus one and fall back to the incoming CF when that reduced count is zero. A selected flag is first cleared and then set from the rule. A flag outside the mask keeps its incoming value. A masked count of zero leaves every flag untouched.

Top module: `srf_flag_gen`

## Requirements
- R1: When the masked shift count is zero, `flags_out` equals `flags_in` for all three bits, whatever the operation and select mask.
- R2: The raw count is masked to its low 5 bits for size codes 0, 1 and 2 (1, 2 and 4 bytes) and to its low 6 bits for size code 3 (8 bytes) before any rule applies. The operand width w is 8, 16, 32 or 64 bits respectively.
- R3: Flag word bit 0 is CF, bit 1 is OF and bit 2 is ECF, in `flags_in`, `flag_sel` and `flags_out` alike. A bit whose select is 0 passes through from `flags_in`. A selected ECF takes the same value as the new CF.
- R4: Op code 0 (shift left): CF is source bit (w - n) when n <= w and 0 otherwise. OF is that CF XOR result bit w-1.
- R5: Op code 1 (logical shift right): CF is source bit (n - 1) when n <= w and 0 otherwise. OF is source bit w-1.
- R6: Op code 2 (arithmetic shift right): with e = min(n, w), CF is source bit (e - 1). A selected OF is cleared.
- R7: Op code 3 (rotate left): CF is result bit 0, and OF is result bit w-1 XOR result bit 0.
- R8: Op code 4 (rotate right): CF is result bit w-1, and OF is result bit w-1 XOR result bit w-2.
- R9: Op code 5 (rotate left through carry): with r = n mod (w + 1), CF is the incoming CF when r is 0 and source bit (w - r) otherwise. OF is result bit w-1 XOR that CF.
- R10: Op code 6 (rotate right through carry): with r = n mod (w + 1), CF is the incoming CF when r is 0 and source bit (r - 1) otherwise. OF is the incoming CF XOR source bit w-1.
- R11: Op code 7 is reserved and leaves `flags_out` equal to `flags_in`.
- R12: With the default registered output, `out_valid` and `flags_out` follow an accepted input by exactly one clock. `out_valid` and `flags_out` are 0 during reset, and `flags_out` holds while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| op | input | 3 | Operation code (0 to 7, see R4 to R11) |
| size | input | 2 | Operand size code: 0=1 B, 1=2 B, 2=4 B, 3=8 B |
| count | input | CNT_W | Raw shift count before masking |
| src | input | 64 | Source operand, low w bits significant |
| res | input | 64 | Shifter result, low w bits significant |
| flags_in | input | 3 | Incoming {ECF, OF, CF} |
| flag_sel | input | 3 | Per-flag write select, same bit order |
| out_valid | output | 1 | Output flags are valid |
| flags_out | output | 3 | Updated {ECF, OF, CF} |

## Verification
The hardest case to reach from the ports is a rotate through carry whose raw count is nonzero but reduces to zero modulo w + 1. Examples are a count of 9 or 18 on a byte operand, or 17 on a two-byte operand. In these cases CF must come from the incoming flag and not from the source. Random counts land there rarely, so the stimulus names these counts directly. It adds raw counts whose masked value is zero while the raw value is not: 32 on four bytes and 64 on eight bytes. A long randomized run with counts biased around the operand width then covers the n <= w boundaries of every rule.

// File: rtl/srf_pkg.sv
package srf_pkg;
   localparam int DATA_W  = 64;
   localparam int NFLAGS  = 3;
   localparam int FLAG_CF  = 0;
   localparam int FLAG_OF  = 1;
   localparam int FLAG_ECF = 2;

   typedef enum logic [2:0] {
      OP_SHL  = 3'd0,
      OP_SHR  = 3'd1,
      OP_SAR  = 3'd2,
      OP_ROL  = 3'd3,
      OP_ROR  = 3'd4,
      OP_RCL  = 3'd5,
      OP_RCR  = 3'd6,
      OP_NONE = 3'd7
   } srf_op_e;

   typedef enum logic [1:0] {
      SZ_B1 = 2'd0,
      SZ_B2 = 2'd1,
      SZ_B4 = 2'd2,
      SZ_B8 = 2'd3
   } srf_size_e;
endpackage

// File: rtl/srf_count_norm.sv
module srf_count_norm #(
   parameter int CNT_W = 8
) (
   input  logic [1:0]       size,
   input  logic [CNT_W-1:0] count_raw,
   output logic [6:0]       width_bits,
   output logic [5:0]       cnt,
   output logic [6:0]       cnt_clamp,
   output logic [6:0]       cnt_rot,
   output logic             cnt_le_w,
   output logic             cnt_zero
);
   import srf_pkg::*;

   // narrow counts never exceed 31, the smallest modulus is 9
   localparam int NARROW_MAX = 31;
   localparam int MIN_MOD    = 9;
   localparam int ROT_STEPS  = (NARROW_MAX + MIN_MOD - 1) / MIN_MOD;

   generate
      if (CNT_W < 6) begin : g_bad_cnt_w
         $error("srf_count_norm: CNT_W must be at least 6");
      end
   endgenerate

   logic [6:0] modulus;
   logic [6:0] rot_acc;
   logic [6:0] cnt_ext;

   always_comb begin
      width_bits = 7'd8 << size;
      if (srf_size_e'(size) == SZ_B8)
         cnt = count_raw[5:0];
      else
         cnt = {1'b0, count_raw[4:0]};
      cnt_ext   = {1'b0, cnt};
      cnt_zero  = (cnt == 6'd0);
      cnt_le_w  = (cnt_ext <= width_bits);
      cnt_clamp = cnt_le_w ? cnt_ext : width_bits;
      modulus   = width_bits + 7'd1;
      rot_acc   = cnt_ext;
      for (int i = 0; i < ROT_STEPS; i++) begin
         if (rot_acc >= modulus)
            rot_acc = rot_acc - modulus;
      end
      cnt_rot = rot_acc;
   end
endmodule

// File: rtl/srf_flag_rules.sv
module srf_flag_rules (
   input  srf_pkg::srf_op_e       op,
   input  logic [6:0]             width_bits,
   input  logic [5:0]             cnt,
   input  logic [6:0]             cnt_clamp,
   input  logic [6:0]             cnt_rot,
   input  logic                   cnt_le_w,
   input  logic [srf_pkg::DATA_W-1:0] src,
   input  logic [srf_pkg::DATA_W-1:0] res,
   input  logic                   cf_in,
   output logic                   cand_cf,
   output logic                   cand_of
);
   import srf_pkg::*;

   logic [5:0] msb_i, smsb_i, shl_i, shr_i, sar_i, rcl_i, rcr_i;
   logic       src_msb, res_msb, rot_zero, rc_cf;

   always_comb begin
      msb_i   = 6'(width_bits - 7'd1);
      smsb_i  = 6'(width_bits - 7'd2);
      shl_i   = 6'(width_bits - {1'b0, cnt});
      shr_i   = cnt - 6'd1;
      sar_i   = 6'(cnt_clamp - 7'd1);
      rcl_i   = 6'(width_bits - cnt_rot);
      rcr_i   = 6'(cnt_rot - 7'd1);
      src_msb = src[msb_i];
      res_msb = res[msb_i];
      rot_zero = (cnt_rot == 7'd0);
      rc_cf   = 1'b0;
      cand_cf = 1'b0;
      cand_of = 1'b0;
      unique case (op)
         OP_SHL: begin
            cand_cf = cnt_le_w & src[shl_i];
            cand_of = cand_cf ^ res_msb;
         end
         OP_SHR: begin
            cand_cf = cnt_le_w & src[shr_i];
            cand_of = src_msb;
         end
         OP_SAR: begin
            cand_cf = src[sar_i];
            cand_of = 1'b0;
         end
         OP_ROL: begin
            cand_cf = res[0];
            cand_of = res_msb ^ res[0];
         end
         OP_ROR: begin
            cand_cf = res_msb;
            cand_of = res_msb ^ res[smsb_i];
         end
         OP_RCL: begin
            rc_cf   = rot_zero ? cf_in : src[rcl_i];
            cand_cf = rc_cf;
            cand_of = res_msb ^ rc_cf;
         end
         OP_RCR: begin
            rc_cf   = rot_zero ? cf_in : src[rcr_i];
            cand_cf = rc_cf;
            cand_of = cf_in ^ src_msb;
         end
         default: begin
            cand_cf = 1'b0;
            cand_of = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/srf_flag_merge.sv
module srf_flag_merge #(
   parameter int NF = srf_pkg::NFLAGS
) (
   input  logic          act,
   input  logic [NF-1:0] flags_in,
   input  logic [NF-1:0] flag_sel,
   input  logic          cand_cf,
   input  logic          cand_of,
   output logic [NF-1:0] flags_next
);
   import srf_pkg::*;

   generate
      if (NF != NFLAGS) begin : g_bad_nf
         $error("srf_flag_merge: NF must match the flag word");
      end
      for (genvar k = 0; k < NF; k++) begin : g_bit
         logic newval;
         if (k == FLAG_OF) begin : g_of
            assign newval = cand_of;
         end else begin : g_carry
            assign newval = cand_cf;
         end
         // clear-then-set collapses to a select of the rule value
         assign flags_next[k] = (act && flag_sel[k]) ? newval : flags_in[k];
      end
   endgenerate
endmodule

// File: rtl/srf_flag_gen.sv
module srf_flag_gen #(
   parameter int CNT_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [2:0]                 op,
   input  logic [1:0]                 size,
   input  logic [CNT_W-1:0]           count,
   input  logic [63:0]                src,
   input  logic [63:0]                res,
   input  logic [2:0]                 flags_in,
   input  logic [2:0]                 flag_sel,
   output logic                       out_valid,
   output logic [2:0]                 flags_out
);
   import srf_pkg::*;

   generate
      if (DATA_W != 64) begin : g_bad_data_w
         $error("srf_flag_gen: datapath must be 64 bits");
      end
   endgenerate

   logic [6:0] width_bits, cnt_clamp, cnt_rot;
   logic [5:0] cnt;
   logic       cnt_le_w, cnt_zero;
   logic       cand_cf, cand_of, act;
   logic [2:0] flags_next;
   srf_op_e    op_e;

   assign op_e = srf_op_e'(op);
   assign act  = !cnt_zero && (op_e != OP_NONE);

   srf_count_norm #(.CNT_W(CNT_W)) u_norm (
      .size       (size),
      .count_raw  (count),
      .width_bits (width_bits),
      .cnt        (cnt),
      .cnt_clamp  (cnt_clamp),
      .cnt_rot    (cnt_rot),
      .cnt_le_w   (cnt_le_w),
      .cnt_zero   (cnt_zero)
   );

   srf_flag_rules u_rules (
      .op         (op_e),
      .width_bits (width_bits),
      .cnt        (cnt),
      .cnt_clamp  (cnt_clamp),
      .cnt_rot    (cnt_rot),
      .cnt_le_w   (cnt_le_w),
      .src        (src),
      .res        (res),
      .cf_in      (flags_in[FLAG_CF]),
      .cand_cf    (cand_cf),
      .cand_of    (cand_of)
   );

   srf_flag_merge #(.NF(NFLAGS)) u_merge (
      .act        (act),
      .flags_in   (flags_in),
      .flag_sel   (flag_sel),
      .cand_cf    (cand_cf),
      .cand_of    (cand_of),
      .flags_next (flags_next)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               flags_out <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid)
                  flags_out <= flags_next;
            end
         end
      end else begin : g_comb
         assign out_valid = in_valid;
         assign flags_out = flags_next;
      end
   endgenerate
endmodule

// File: rtl/srf_flag_gen_chk.sv
module srf_flag_gen_chk #(
   parameter int CNT_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [2:0]       op,
   input logic [1:0]       size,
   input logic [CNT_W-1:0] count,
   input logic [2:0]       flags_in,
   input logic [2:0]       flag_sel,
   input logic             out_valid,
   input logic [2:0]       flags_out
);
   logic [5:0] mcnt;
   logic       hi_set;
   logic       live;

   assign mcnt   = (size == 2'd3) ? count[5:0] : {1'b0, count[4:0]};
   assign hi_set = |(count >> 6);
   assign live   = in_valid && (mcnt != 6'd0) && (op != 3'd7);

   generate
      if (OUT_REG) begin : g_seq
         p_zero_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mcnt == 6'd0) |=> (flags_out == $past(flags_in)));

         p_wide_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && size == 2'd3 && count[5:0] == 6'd0 && hi_set)
            |=> (flags_out == $past(flags_in)));

         p_unselected_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (((flags_out ^ $past(flags_in)) & ~$past(flag_sel)) == 3'b000));

         p_ecf_tracks_cf_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (live && flag_sel[0] && flag_sel[2]) |=> (flags_out[2] == flags_out[0]));

         p_sar_no_of_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (live && op == 3'd2 && flag_sel[1]) |=> !flags_out[1]);

         p_reserved_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == 3'd7) |=> (flags_out == $past(flags_in)));

         p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

         p_valid_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(flags_out)));
      end else begin : g_comb
         p_zero_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mcnt == 6'd0) |-> (flags_out == flags_in));

         p_unselected_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (((flags_out ^ flags_in) & ~flag_sel) == 3'b000));

         p_reserved_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == 3'd7) |-> (flags_out == flags_in));

         p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
      end
   endgenerate
endmodule

bind srf_flag_gen srf_flag_gen_chk #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .size      (size),
   .count     (count),
   .flags_in  (flags_in),
   .flag_sel  (flag_sel),
   .out_valid (out_valid),
   .flags_out (flags_out)
);

// File: tb/srf_flag_gen_test.sv
module srf_flag_gen_test;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [2:0]       op = '0;
   logic [1:0]       size = '0;
   logic [CNT_W-1:0] count = '0;
   logic [63:0]      src = '0;
   logic [63:0]      res = '0;
   logic [2:0]       flags_in = '0;
   logic [2:0]       flag_sel = '0;
   logic             out_valid;
   logic [2:0]       flags_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic vin_d = 1'b0;

   typedef struct {
      logic [2:0] exp;
      string      tag;
   } item_t;
   item_t q[$];

   always #5 clk = ~clk;

   srf_flag_gen #(.CNT_W(CNT_W), .OUT_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
      .count(count), .src(src), .res(res), .flags_in(flags_in),
      .flag_sel(flag_sel), .out_valid(out_valid), .flags_out(flags_out)
   );

   function automatic logic pick(input logic [63:0] v, input int i);
      return v[i];
   endfunction

   // reference model written from the requirements
   function automatic logic [2:0] model(input int o, input int sz, input int c,
                                        input logic [63:0] s, input logic [63:0] r,
                                        input logic [2:0] fi, input logic [2:0] sel);
      int w, n, e, rr;
      logic cf, ov;
      logic [2:0] out;
      w = 8 << sz;                                  // R2
      n = (sz == 3) ? (c % 64) : (c % 32);          // R2
      out = fi;
      if (n == 0 || o == 7) return out;             // R1, R11
      cf = 1'b0; ov = 1'b0;
      case (o)
         0: begin cf = (n <= w) ? pick(s, w - n) : 1'b0; ov = cf ^ pick(r, w - 1); end
         1: begin cf = (n <= w) ? pick(s, n - 1) : 1'b0; ov = pick(s, w - 1); end
         2: begin e = (n > w) ? w : n; cf = pick(s, e - 1); ov = 1'b0; end
         3: begin cf = pick(r, 0); ov = pick(r, w - 1) ^ pick(r, 0); end
         4: begin cf = pick(r, w - 1); ov = pick(r, w - 1) ^ pick(r, w - 2); end
         5: begin rr = n % (w + 1); cf = (rr == 0) ? fi[0] : pick(s, w - rr);
                  ov = pick(r, w - 1) ^ cf; end
         default: begin rr = n % (w + 1); cf = (rr == 0) ? fi[0] : pick(s, rr - 1);
                  ov = fi[0] ^ pick(s, w - 1); end
      endcase
      if (sel[0]) out[0] = cf;
      if (sel[1]) out[1] = ov;
      if (sel[2]) out[2] = cf;                      // R3
      return out;
   endfunction

   function automatic string op_tag(input int o);
      case (o)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         3: return "R7";
         4: return "R8";
         5: return "R9";
         6: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic send(input int o, input int sz, input int c, input logic [63:0] s,
                       input logic [63:0] r, input logic [2:0] fi, input logic [2:0] sel,
                       input string tag);
      item_t it;
      @(negedge clk);
      in_valid = 1'b1; op = 3'(o); size = 2'(sz); count = CNT_W'(c);
      src = s; res = r; flags_in = fi; flag_sel = sel;
      it.exp = model(o, sz, c, s, r, fi, sel);
      it.tag = (tag == "") ? op_tag(o) : tag;
      q.push_back(it);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // scoreboard monitor
   always @(posedge clk) vin_d <= rst_n ? in_valid : 1'b0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (out_valid !== vin_d) begin
            errors++;
            $display("FAIL R12 out_valid actual %0b expected %0b", out_valid, vin_d);
         end
         if (out_valid === 1'b1) begin
            if (q.size() == 0) begin
               errors++;
               $display("FAIL R12 unexpected output actual %b expected none", flags_out);
            end else begin
               item_t it;
               it = q.pop_front();
               checks++;
               if (flags_out !== it.exp) begin
                  errors++;
                  $display("FAIL %s flags actual %b expected %b", it.tag, flags_out, it.exp);
               end
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || flags_out !== 3'b000) begin
         errors++;
         $display("FAIL R12 reset actual %b/%b expected 0/000", out_valid, flags_out);
      end
      rst_n = 1'b1;

      // R1: zero count holds everything
      send(0, 0, 0, 64'hFF, 64'hFF, 3'b101, 3'b111, "R1");
      send(6, 3, 0, 64'h1, 64'h0, 3'b010, 3'b111, "R1");
      // R2: masking of the raw count
      send(1, 2, 32, 64'hFFFF_FFFF, 64'h0, 3'b000, 3'b111, "R2");
      send(1, 2, 40, 64'h80, 64'h0, 3'b000, 3'b111, "R2");
      send(1, 3, 64, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 3'b010, 3'b111, "R2");
      send(1, 3, 33, 64'h1_0000_0000, 64'h0, 3'b000, 3'b111, "R2");
      // R3: select mask behaviour
      send(0, 0, 1, 64'h80, 64'h00, 3'b010, 3'b000, "R3");
      send(0, 0, 1, 64'h80, 64'h00, 3'b000, 3'b100, "R3");
      send(4, 1, 3, 64'h0, 64'h8000, 3'b011, 3'b101, "R3");
      // R4: shift left at and beyond the width
      send(0, 0, 8, 64'h01, 64'h00, 3'b000, 3'b111, "R4");
      send(0, 0, 9, 64'hFF, 64'h00, 3'b111, 3'b111, "R4");
      // R5 and R6 boundaries
      send(1, 0, 8, 64'h80, 64'h00, 3'b000, 3'b111, "R5");
      send(2, 0, 20, 64'h80, 64'hFF, 3'b010, 3'b111, "R6");
      send(2, 3, 63, 64'h4000_0000_0000_0000, 64'h0, 3'b010, 3'b011, "R6");
      // R7, R8
      send(3, 2, 5, 64'h0, 64'h8000_0001, 3'b000, 3'b111, "R7");
      send(4, 0, 2, 64'h0, 64'h40, 3'b000, 3'b111, "R8");
      // R9, R10: reduced count of zero reuses incoming CF
      send(5, 0, 9, 64'h00, 64'h80, 3'b001, 3'b111, "R9");
      send(5, 0, 18, 64'hFF, 64'h00, 3'b000, 3'b111, "R9");
      send(5, 1, 17, 64'hFFFF, 64'h0, 3'b001, 3'b111, "R9");
      send(5, 0, 10, 64'h80, 64'h00, 3'b000, 3'b111, "R9");
      send(6, 0, 27, 64'hFF, 64'h00, 3'b000, 3'b111, "R10");
      send(6, 0, 3, 64'h84, 64'h00, 3'b001, 3'b111, "R10");
      // R11
      send(7, 2, 5, 64'hFFFF, 64'hFFFF, 3'b110, 3'b111, "R11");
      idle();
      idle();

      // randomized sweep, counts biased around the width
      for (int i = 0; i < 3000; i++) begin
         int o, sz, c;
         o  = $urandom % 8;
         sz = $urandom % 4;
         if ($urandom % 2) c = $urandom % ((8 << sz) + 3);
         else c = $urandom % 256;
         send(o, sz, c, {$urandom, $urandom}, {$urandom, $urandom},
              3'($urandom), 3'($urandom), "");
         if ($urandom % 8 == 0) idle();
      end
      idle();
      idle();
      idle();
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R12 pending items actual %0d expected 0", q.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL R12 watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule